// File: doc/BRIEF.md
# Checkpoint Undo-Log Controller

This block sits beside a memory directory and lets memory be rewound to the most recent coarse-grain checkpoint. Stores go to memory in place. The first time a line is claimed for exclusive access after a checkpoint, the block reads the clean line and pushes it, with its address, onto a history buffer that the block owns. It then marks the line so that later claims to it within the same interval cost nothing.

A checkpoint commit throws the whole log away in a single cycle. It clears every line mark and resets the log pointer, and no entry is erased one at a time. A rollback replays the log newest-first over memory, one line per cycle, through a simple line write port. It then pulses a done strobe and clears the marks. If the log has no room for a new first-touch entry, the request is refused and a sticky overflow flag is raised. The caller is expected to force a checkpoint or abort the interval.

Top module: `ckpt_undo_log`

## Requirements
- R1: After reset, `ready` is 1, `overflow` is 0, neither memory enable is active, the log is empty and no line is marked.
- R2: An exclusive request to an unmarked line, taken while `ready` is 1 and the log is not full, drives `memRdEn` with `memAddr` equal to the request address in that same cycle. In the next cycle `ready` is 0 and `exclAck` is 1. The data returned one cycle after the read is stored with the address as the newest log entry, and the line becomes marked.
- R3: An exclusive request to a line that is already marked gives `exclAck` in the same cycle. It causes no memory read and adds no log entry.
- R4: A commit taken while `ready` is 1 clears every line mark and empties the log, both effective in the next cycle.
- R5: A rollback taken while `ready` is 1 holds `ready` at 0. In each following cycle it issues one `memWrEn` with the newest remaining entry's address and data, newest first, until the log is empty. This leaves memory as it was at the last commit.
- R6: The cycle after the last replay write, or the cycle after acceptance if the log was already empty, `rollbackDone` pulses for one cycle and all line marks are cleared. `ready` returns to 1 in the following cycle.
- R7: An exclusive request to an unmarked line when the log holds its full depth gives `exclNack` in the same cycle. It makes no read and adds no entry. `overflow` goes to 1 from the next cycle and stays there until reset.
- R8: If rollback and commit are requested in the same accepted cycle, only the rollback takes effect. The log is replayed intact.
- R9: Requests of any kind that arrive while `ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| commitReq | input | 1 | Commit the current checkpoint (discard the log) |
| rollbackReq | input | 1 | Restore memory to the last checkpoint |
| exclReq | input | 1 | Exclusive-access claim for a line |
| exclAddr | input | AW | Line address of the claim |
| ready | output | 1 | Block can accept a request this cycle |
| exclAck | output | 1 | Claim granted, and the line is safe to overwrite |
| exclNack | output | 1 | Claim refused because the log is full |
| memRdEn | output | 1 | Line read request to memory (data one cycle later) |
| memWrEn | output | 1 | Line write to memory during replay |
| memAddr | output | AW | Line address for read or write |
| memWrData | output | LINE_W | Line data for replay writes |
| memRdData | input | LINE_W | Line data returned one cycle after `memRdEn` |
| rollbackDone | output | 1 | One-cycle pulse when replay has finished |
| overflow | output | 1 | Sticky flag: a claim was refused for lack of log space |

## Verification
The properties assume that memory answers a read exactly one cycle after `memRdEn`. They also assume that `exclAddr` stays below the tracked line count, and that nothing else writes a line between its read and its capture, or during a replay. The stimulus writes a line only after its claim has been acknowledged. It keeps its own writes out of replay windows and draws every address from the tracked range. It also drives requests while `ready` is low, on purpose, to confirm that they are dropped.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPT,
    ST_ROLL
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrLogged;
    logic rstPtr;
    logic latchAddr;
    logic pushEntry;
    logic popEntry;
    logic setOverflow;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lineLogged;
    logic histFull;
    logic histEmpty;
  } dpStatus_t;

endpackage

// File: rtl/undo_hist_ram.sv
module undo_hist_ram #(
  parameter int ENTRY_W = 36,
  parameter int DEPTH   = 8,
  localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               wrEn,
  input  logic [IW-1:0]      wrIdx,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic [IW-1:0]      rdIdx,
  output logic [ENTRY_W-1:0] rdData
);

  logic [ENTRY_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrIdx] <= wrData;
  end

  assign rdData = store[rdIdx];

endmodule

// File: rtl/undo_log_ctrl.sv
module undo_log_ctrl
  import undo_log_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       commitReq,
  input  logic       rollbackReq,
  input  logic       exclReq,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       ready,
  output logic       exclAck,
  output logic       exclNack,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       rollbackDone
);

  ctlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD       = stateQ;
    strobe       = '0;
    ready        = 1'b0;
    exclAck      = 1'b0;
    exclNack     = 1'b0;
    memRdEn      = 1'b0;
    memWrEn      = 1'b0;
    rollbackDone = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        ready = 1'b1;
        if (rollbackReq) begin
          // rollback wins over a simultaneous commit
          stateD = ST_ROLL;
        end else if (commitReq) begin
          strobe.clrLogged = 1'b1;
          strobe.rstPtr    = 1'b1;
        end else if (exclReq) begin
          if (status.lineLogged) begin
            exclAck = 1'b1;
          end else if (status.histFull) begin
            exclNack           = 1'b1;
            strobe.setOverflow = 1'b1;
          end else begin
            memRdEn          = 1'b1;
            strobe.latchAddr = 1'b1;
            stateD           = ST_CAPT;
          end
        end
      end
      ST_CAPT: begin
        strobe.pushEntry = 1'b1;
        exclAck          = 1'b1;
        stateD           = ST_IDLE;
      end
      ST_ROLL: begin
        if (status.histEmpty) begin
          rollbackDone     = 1'b1;
          strobe.clrLogged = 1'b1;
          strobe.rstPtr    = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          strobe.popEntry = 1'b1;
          memWrEn         = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/undo_log_dp.sv
module undo_log_dp
  import undo_log_pkg::*;
#(
  parameter int LINE_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int HIST_DEPTH = 8,
  localparam int AW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int IW        = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1,
  localparam int PW        = $clog2(HIST_DEPTH + 1),
  localparam int ENTRY_W   = AW + LINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [AW-1:0]     exclAddr,
  input  logic [LINE_W-1:0] memRdData,
  output logic [AW-1:0]     memAddr,
  output logic [LINE_W-1:0] memWrData,
  output dpStatus_t         status,
  output logic              overflow
);

  logic [NUM_LINES-1:0] loggedBits;
  logic [AW-1:0]        capAddr;
  logic [PW-1:0]        tailPtr;
  logic [PW-1:0]        tailMinus1;
  logic [ENTRY_W-1:0]   topEntry;
  logic [AW-1:0]        topAddr;
  logic                 ovfQ;

  // one mark per tracked line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic markQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                           markQ <= 1'b0;
      else if (strobe.clrLogged)                           markQ <= 1'b0;
      else if (strobe.pushEntry && capAddr == AW'(g))      markQ <= 1'b1;
    end
    assign loggedBits[g] = markQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 capAddr <= '0;
    else if (strobe.latchAddr) capAddr <= exclAddr;
  end

  // log is a stack: base fixed at entry 0, tail is the fill count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tailPtr <= '0;
    else if (strobe.rstPtr)    tailPtr <= '0;
    else if (strobe.pushEntry) tailPtr <= tailPtr + PW'(1);
    else if (strobe.popEntry)  tailPtr <= tailMinus1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   ovfQ <= 1'b0;
    else if (strobe.setOverflow) ovfQ <= 1'b1;
  end

  assign tailMinus1 = tailPtr - PW'(1);

  undo_hist_ram #(
    .ENTRY_W (ENTRY_W),
    .DEPTH   (HIST_DEPTH)
  ) u_hist (
    .clk    (clk),
    .wrEn   (strobe.pushEntry),
    .wrIdx  (tailPtr[IW-1:0]),
    .wrData ({capAddr, memRdData}),
    .rdIdx  (tailMinus1[IW-1:0]),
    .rdData (topEntry)
  );

  assign topAddr   = topEntry[ENTRY_W-1 -: AW];
  assign memWrData = topEntry[LINE_W-1:0];
  assign memAddr   = strobe.popEntry ? topAddr : exclAddr;

  assign status.lineLogged = loggedBits[exclAddr];
  assign status.histFull   = (tailPtr == PW'(HIST_DEPTH));
  assign status.histEmpty  = (tailPtr == '0);
  assign overflow          = ovfQ;

endmodule

// File: rtl/ckpt_undo_log.sv
module ckpt_undo_log
  import undo_log_pkg::*;
#(
  parameter int LINE_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int HIST_DEPTH = 8,
  localparam int AW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commitReq,
  input  logic              rollbackReq,
  input  logic              exclReq,
  input  logic [AW-1:0]     exclAddr,
  output logic              ready,
  output logic              exclAck,
  output logic              exclNack,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [AW-1:0]     memAddr,
  output logic [LINE_W-1:0] memWrData,
  input  logic [LINE_W-1:0] memRdData,
  output logic              rollbackDone,
  output logic              overflow
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  undo_log_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .commitReq    (commitReq),
    .rollbackReq  (rollbackReq),
    .exclReq      (exclReq),
    .status       (status),
    .strobe       (strobe),
    .ready        (ready),
    .exclAck      (exclAck),
    .exclNack     (exclNack),
    .memRdEn      (memRdEn),
    .memWrEn      (memWrEn),
    .rollbackDone (rollbackDone)
  );

  undo_log_dp #(
    .LINE_W     (LINE_W),
    .NUM_LINES  (NUM_LINES),
    .HIST_DEPTH (HIST_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .exclAddr  (exclAddr),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .status    (status),
    .overflow  (overflow)
  );

endmodule

// File: rtl/ckpt_undo_log_chk.sv
module ckpt_undo_log_chk (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic exclAck,
  input logic exclNack,
  input logic memRdEn,
  input logic memWrEn,
  input logic rollbackDone,
  input logic overflow
);

  // R2: a capture read happens only in an accepting cycle, then the ack follows
  p_read_in_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ready && !exclAck);
  p_read_then_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> exclAck && !ready);

  // R3: one response at most per claim
  p_single_response_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(exclAck && exclNack));

  // R5: replay writes only while busy, never alongside a read
  p_write_while_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !ready && !memRdEn);

  // R6: done is a single pulse, followed by readiness
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rollbackDone |-> !ready ##1 (!rollbackDone && ready));

  // R7: refusal raises the flag, and the flag never drops
  p_nack_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    exclNack |=> overflow);
  p_no_overflow_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

endmodule

bind ckpt_undo_log ckpt_undo_log_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ready        (ready),
  .exclAck      (exclAck),
  .exclNack     (exclNack),
  .memRdEn      (memRdEn),
  .memWrEn      (memWrEn),
  .rollbackDone (rollbackDone),
  .overflow     (overflow)
);

// File: tb/ckpt_undo_log_tb.sv
module ckpt_undo_log_tb;

  localparam int LW    = 32;
  localparam int NL    = 16;
  localparam int DEPTH = 4;
  localparam int AW    = $clog2(NL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic commitReq = 1'b0, rollbackReq = 1'b0, exclReq = 1'b0;
  logic [AW-1:0] exclAddr = '0;
  logic ready, exclAck, exclNack, memRdEn, memWrEn, rollbackDone, overflow;
  logic [AW-1:0] memAddr;
  logic [LW-1:0] memWrData;
  logic [LW-1:0] memRdData;

  // bench-side stores into memory
  logic storeEn = 1'b0;
  logic [AW-1:0] storeAddr = '0;
  logic [LW-1:0] storeData = '0;

  always #10 clk = ~clk;  // 50 MHz

  ckpt_undo_log #(.LINE_W(LW), .NUM_LINES(NL), .HIST_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .commitReq(commitReq), .rollbackReq(rollbackReq),
    .exclReq(exclReq), .exclAddr(exclAddr), .ready(ready), .exclAck(exclAck),
    .exclNack(exclNack), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .rollbackDone(rollbackDone),
    .overflow(overflow)
  );

  // backing memory, one-cycle read latency
  logic [LW-1:0] mem [NL];
  logic [LW-1:0] snap [NL];
  initial for (int i = 0; i < NL; i++) mem[i] = 32'hA000_0000 + LW'(i);

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) mem[memAddr] <= memWrData;
    if (storeEn) mem[storeAddr] <= storeData;
  end

  int unsigned vecs = 0, bad = 0;
  bit finished = 0;

  task automatic cmp(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPhase = 0;  // 0 idle, 1 capture, 2 replay
  bit mLogged [NL];
  bit mOvf = 0;
  logic [AW-1:0] mCap;
  logic [AW-1:0] qAddr [$];
  logic [LW-1:0] qData [$];
  logic [LW-1:0] refMem [NL];
  initial for (int i = 0; i < NL; i++) refMem[i] = 32'hA000_0000 + LW'(i);

  always begin : model
    string tag;
    bit eReady, eRd, eWr, eAck, eNack, eDone, eOvf;
    logic [AW-1:0] eAddr;
    logic [LW-1:0] eData;
    @(posedge clk);
    #15;
    eReady = 0; eRd = 0; eWr = 0; eAck = 0; eNack = 0; eDone = 0;
    eAddr = '0; eData = '0; eOvf = mOvf; tag = "R2";
    if (!rstN) begin
      tag = "R1"; eReady = 1; eOvf = 0;
    end else begin
      case (mPhase)
        0: begin
          eReady = 1;
          if (rollbackReq) begin
            tag = commitReq ? "R8" : "R5";
            mPhase = 2;
          end else if (commitReq) begin
            tag = "R4";
            for (int i = 0; i < NL; i++) mLogged[i] = 0;
            qAddr.delete(); qData.delete();
          end else if (exclReq) begin
            if (mLogged[exclAddr]) begin
              tag = "R3"; eAck = 1;
            end else if (qAddr.size() == DEPTH) begin
              tag = "R7"; eNack = 1; mOvf = 1;
            end else begin
              tag = "R2"; eRd = 1; eAddr = exclAddr; mCap = exclAddr; mPhase = 1;
            end
          end else tag = "R1";
        end
        1: begin
          tag = (exclReq || commitReq || rollbackReq) ? "R9" : "R2";
          eAck = 1;
          qAddr.push_back(mCap); qData.push_back(refMem[mCap]);
          mLogged[mCap] = 1;
          mPhase = 0;
        end
        default: begin
          if (qAddr.size() == 0) begin
            tag = "R6"; eDone = 1;
            for (int i = 0; i < NL; i++) mLogged[i] = 0;
            mPhase = 0;
          end else begin
            tag = (exclReq || commitReq || rollbackReq) ? "R9" : "R5";
            eWr = 1; eAddr = qAddr[$]; eData = qData[$];
            refMem[eAddr] = eData;
            void'(qAddr.pop_back()); void'(qData.pop_back());
          end
        end
      endcase
    end
    vecs++;
    cmp(tag, "ready", 64'(ready), 64'(eReady));
    cmp(tag, "memRdEn", 64'(memRdEn), 64'(eRd));
    cmp(tag, "memWrEn", 64'(memWrEn), 64'(eWr));
    cmp(tag, "exclAck", 64'(exclAck), 64'(eAck));
    cmp(tag, "exclNack", 64'(exclNack), 64'(eNack));
    cmp(tag, "rollbackDone", 64'(rollbackDone), 64'(eDone));
    cmp("R7", "overflow", 64'(overflow), 64'(eOvf));
    if (eRd || eWr) cmp(tag, "memAddr", 64'(memAddr), 64'(eAddr));
    if (eWr) cmp(tag, "memWrData", 64'(memWrData), 64'(eData));
    if (!rstN) begin
      mPhase = 0; mOvf = 0;
      for (int i = 0; i < NL; i++) mLogged[i] = 0;
      qAddr.delete(); qData.delete();
    end
    if (storeEn) refMem[storeAddr] = storeData;
  end

  // ---------------- stimulus ----------------
  logic [LW-1:0] nextVal = 32'hD000_0000;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic waitReady();
    while (!ready) tick();
  endtask

  task automatic claim(input logic [AW-1:0] a);
    waitReady();
    exclReq = 1; exclAddr = a;
    tick();
    exclReq = 0;
  endtask

  task automatic store(input logic [AW-1:0] a);
    storeEn = 1; storeAddr = a; storeData = nextVal; nextVal++;
    tick();
    storeEn = 0;
  endtask

  task automatic commit();
    waitReady();
    commitReq = 1;
    tick();
    commitReq = 0;
    for (int i = 0; i < NL; i++) snap[i] = mem[i];
  endtask

  task automatic rollback(input bit withCommit);
    waitReady();
    rollbackReq = 1; commitReq = withCommit;
    tick();
    rollbackReq = 0; commitReq = 0;
    tick();
    waitReady();
  endtask

  task automatic checkSnap(string tag);
    tick();
    for (int i = 0; i < NL; i++) begin
      vecs++;
      cmp(tag, "memory line", 64'(mem[i]), 64'(snap[i]));
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();          // R1 reset state compared by model
    rstN = 1;
    tick();
    commit();                   // R4 initial checkpoint
    // R2 first touch, R3 repeat touch
    claim(3); store(3);
    claim(3); store(3);
    claim(5); store(5);
    claim(9); store(9);
    rollback(0);                // R5 replay, R6 done
    checkSnap("R5");
    // R6 marks cleared: line 3 logs again; R4 commit discards log
    claim(3); store(3);
    commit();
    claim(3); store(3);
    claim(12); store(12);
    rollback(0);
    checkSnap("R4");
    // R7 fill the log then overflow
    claim(0); store(0);
    claim(1); store(1);
    claim(2); store(2);
    claim(3); store(3);
    claim(7);                   // refused
    claim(0); store(0);         // R3 still granted when full
    rollback(1);                // R8 rollback beats commit
    checkSnap("R8");
    // R9 requests during busy replay are dropped
    claim(4); store(4);
    claim(6); store(6);
    waitReady();
    rollbackReq = 1;
    tick();
    rollbackReq = 0; exclReq = 1; exclAddr = 8; commitReq = 1;
    tick();
    tick();
    exclReq = 0; commitReq = 0;
    waitReady();
    checkSnap("R9");
    // R6 rollback of an empty log
    commit();
    rollback(0);
    checkSnap("R6");
    repeat (3) tick();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finishRun();
  end

endmodule